// File: doc/BRIEF.md
# Grouped GPIO Interrupt Controller

This block turns general-purpose input pins into one shared interrupt request. The pins are grouped into byte-wide lane groups. Eight interrupt slots serve every pin. Each slot has its own group selector that steers it to one lane group. Inside that group, a slot always watches the bit whose index equals the slot number. A pin at index p of port q is therefore served by slot p mod 8, with the selector set to 4·q + p/8.

Each slot has a three-bit trigger code, which can choose off, level high, level low, a forced "set" state, rising edge, falling edge or any edge. Each slot also has a mask bit and a raw status bit. Edge events latch in the status bit until software clears them with a write-one-to-clear acknowledge. The masked status bits are ORed together into one registered interrupt line.

Software programs and observes the block through a small synchronous register port. A write is taken on the clock edge on which the write strobe is high. Read data follows the address combinationally.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: Register addresses are: 0 trigger config, 1 group select, 2 mask, 3 acknowledge, 4 raw status, 5 masked status. Config keeps only bits 23:0, group select keeps bits 31:0 and mask keeps only bits 7:0. Writes are read back unchanged in the kept bits, and the other bits read as 0. The acknowledge address and unused addresses read 0.
- R2: After reset, the config, group-select, mask, raw and masked status registers all read 0, and the interrupt output is low.
- R3: The selector of slot k is field [4k+3:4k] of group select. Slot k watches input bit 8·sel + k and no other pin.
- R4: The trigger code of slot k is field [3k+2:3k] of config. Codes 0 and 4 hold raw status bit k at 0.
- R5: Code 1 makes raw status equal the synchronised pin, and code 2 makes it equal the inverted synchronised pin. In both level modes an acknowledge has no effect.
- R6: Code 3 holds raw status bit k at 1.
- R7: Codes 5, 6 and 7 latch raw status on a rising edge, a falling edge or either edge of the synchronised pin. The bit stays set after the pin returns to its old level. Leaving the edge modes drops the latched bit.
- R8: Writing the acknowledge register clears the latched event of every slot whose bit is 1, and leaves slots whose bit is 0 unchanged.
- R9: If an acknowledge and a new edge on the same slot land in the same cycle, the status bit stays set.
- R10: Masked status equals raw status AND mask.
- R11: A pin change reaches level-mode raw status after two clock edges and edge-mode status after three. The interrupt output is the OR of the masked status bits, delayed by one register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| gpio_in | input | NUM_PORTS*PORT_W (128) | Asynchronous GPIO inputs, port q in bits [32q+31:32q] |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W (3) | Register address |
| reg_wdata | input | DATA_W (32) | Register write data |
| reg_rdata | output | DATA_W (32) | Register read data (combinational) |
| irq | output | 1 | Shared interrupt request |

## Verification
The two functions that can collide are a software acknowledge and a freshly detected edge on the same slot. Both act on the same status flop at the same clock edge. The bench provokes this by changing a pin and then timing the acknowledge write so that it commits on the exact edge where the synchronised pin first differs from its delayed copy. It then requires the status bit to read 1. A second acknowledge, one cycle later and with no edge pending, must clear the bit. This shows that the first outcome came from the priority rule and not from an acknowledge that failed to take effect.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

  localparam int unsigned TRIG_W = 3;

  typedef enum logic [TRIG_W-1:0] {
    TRIG_OFF  = 3'd0,
    TRIG_HIGH = 3'd1,
    TRIG_LOW  = 3'd2,
    TRIG_SET  = 3'd3,
    TRIG_RSVD = 3'd4,
    TRIG_RISE = 3'd5,
    TRIG_FALL = 3'd6,
    TRIG_ANY  = 3'd7
  } trig_e;

  localparam logic [2:0] RA_TRIG   = 3'd0;
  localparam logic [2:0] RA_GSEL   = 3'd1;
  localparam logic [2:0] RA_MASK   = 3'd2;
  localparam logic [2:0] RA_ACK    = 3'd3;
  localparam logic [2:0] RA_RAW    = 3'd4;
  localparam logic [2:0] RA_MASKED = 3'd5;

  function automatic logic is_edge_mode(logic [TRIG_W-1:0] m);
    return (m == TRIG_RISE) || (m == TRIG_FALL) || (m == TRIG_ANY);
  endfunction

endpackage

// File: rtl/gpio_irq_sync.sv
module gpio_irq_sync #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] meta_q;
  logic [W-1:0] stab_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      stab_q <= '0;
    end else begin
      meta_q <= d;
      stab_q <= meta_q;
    end
  end

  assign q = stab_q;

endmodule

// File: rtl/gpio_irq_lane_mux.sv
module gpio_irq_lane_mux #(
  parameter int unsigned NUM_SLOTS  = 8,
  parameter int unsigned LANE_W     = 8,
  parameter int unsigned NUM_GROUPS = 16,
  parameter int unsigned GSEL_W     = 4,
  localparam int unsigned PIN_W     = NUM_GROUPS * LANE_W
) (
  input  logic [PIN_W-1:0]            pins,
  input  logic [NUM_SLOTS*GSEL_W-1:0] gsel,
  output logic [NUM_SLOTS-1:0]        tap
);

  for (genvar k = 0; k < NUM_SLOTS; k++) begin : g_slot
    logic [GSEL_W-1:0] sel;
    assign sel = gsel[k*GSEL_W +: GSEL_W];

    always_comb begin
      tap[k] = 1'b0;
      for (int g = 0; g < NUM_GROUPS; g++) begin
        if (sel == GSEL_W'(g)) tap[k] = pins[g*LANE_W + k];
      end
    end
  end

endmodule

// File: rtl/gpio_irq_slot.sv
module gpio_irq_slot
  import gpio_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [TRIG_W-1:0] mode,
  input  logic              pin_s,
  input  logic              ack,
  output logic              raw,
  output logic              edge_hit
);

  logic prev_q, prev_d;
  logic sticky_q, sticky_d;
  logic rise, fall, edge_mode;

  assign rise      = pin_s & ~prev_q;
  assign fall      = ~pin_s & prev_q;
  assign edge_mode = is_edge_mode(mode);

  always_comb begin
    unique case (trig_e'(mode))
      TRIG_RISE: edge_hit = rise;
      TRIG_FALL: edge_hit = fall;
      TRIG_ANY:  edge_hit = rise | fall;
      default:   edge_hit = 1'b0;
    endcase
  end

  always_comb begin
    prev_d   = pin_s;
    sticky_d = edge_mode ? (edge_hit | (sticky_q & ~ack)) : 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q   <= 1'b0;
      sticky_q <= 1'b0;
    end else begin
      prev_q   <= prev_d;
      sticky_q <= sticky_d;
    end
  end

  always_comb begin
    unique case (trig_e'(mode))
      TRIG_HIGH: raw = pin_s;
      TRIG_LOW:  raw = ~pin_s;
      TRIG_SET:  raw = 1'b1;
      TRIG_RISE,
      TRIG_FALL,
      TRIG_ANY:  raw = sticky_q;
      default:   raw = 1'b0;
    endcase
  end

endmodule

// File: rtl/gpio_irq_regs.sv
module gpio_irq_regs
  import gpio_irq_pkg::*;
#(
  parameter int unsigned NUM_SLOTS = 8,
  parameter int unsigned GSEL_W    = 4,
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned ADDR_W    = 3,
  localparam int unsigned TCFG_W   = NUM_SLOTS * TRIG_W,
  localparam int unsigned GCFG_W   = NUM_SLOTS * GSEL_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 reg_we,
  input  logic [ADDR_W-1:0]    reg_addr,
  input  logic [DATA_W-1:0]    reg_wdata,
  input  logic [NUM_SLOTS-1:0] raw,
  output logic [DATA_W-1:0]    reg_rdata,
  output logic [TCFG_W-1:0]    trig_cfg,
  output logic [GCFG_W-1:0]    gsel_cfg,
  output logic [NUM_SLOTS-1:0] mask,
  output logic [NUM_SLOTS-1:0] ack_pulse,
  output logic                 trig_we
);

  logic [TCFG_W-1:0]    trig_q, trig_d;
  logic [GCFG_W-1:0]    gsel_q, gsel_d;
  logic [NUM_SLOTS-1:0] mask_q, mask_d;
  logic                 gsel_we, mask_we;

  assign trig_we = reg_we && (reg_addr == ADDR_W'(RA_TRIG));
  assign gsel_we = reg_we && (reg_addr == ADDR_W'(RA_GSEL));
  assign mask_we = reg_we && (reg_addr == ADDR_W'(RA_MASK));

  assign ack_pulse = (reg_we && (reg_addr == ADDR_W'(RA_ACK)))
                     ? reg_wdata[NUM_SLOTS-1:0] : '0;

  always_comb begin
    trig_d = trig_q;
    gsel_d = gsel_q;
    mask_d = mask_q;
    if (trig_we) trig_d = reg_wdata[TCFG_W-1:0];
    if (gsel_we) gsel_d = reg_wdata[GCFG_W-1:0];
    if (mask_we) mask_d = reg_wdata[NUM_SLOTS-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trig_q <= '0;
      gsel_q <= '0;
      mask_q <= '0;
    end else begin
      if (trig_we) trig_q <= trig_d;
      if (gsel_we) gsel_q <= gsel_d;
      if (mask_we) mask_q <= mask_d;
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      ADDR_W'(RA_TRIG):   reg_rdata = DATA_W'(trig_q);
      ADDR_W'(RA_GSEL):   reg_rdata = DATA_W'(gsel_q);
      ADDR_W'(RA_MASK):   reg_rdata = DATA_W'(mask_q);
      ADDR_W'(RA_RAW):    reg_rdata = DATA_W'(raw);
      ADDR_W'(RA_MASKED): reg_rdata = DATA_W'(raw & mask_q);
      default:            reg_rdata = '0;
    endcase
  end

  assign trig_cfg = trig_q;
  assign gsel_cfg = gsel_q;
  assign mask     = mask_q;

endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
  import gpio_irq_pkg::*;
#(
  parameter int unsigned NUM_PORTS = 4,
  parameter int unsigned PORT_W    = 32,
  parameter int unsigned LANE_W    = 8,
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned ADDR_W    = 3,
  localparam int unsigned NUM_SLOTS  = LANE_W,
  localparam int unsigned PIN_W      = NUM_PORTS * PORT_W,
  localparam int unsigned NUM_GROUPS = PIN_W / LANE_W,
  localparam int unsigned GSEL_W     = $clog2(NUM_GROUPS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PIN_W-1:0]  gpio_in,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              irq
);

  logic [NUM_SLOTS*TRIG_W-1:0] trig_cfg;
  logic [NUM_SLOTS*GSEL_W-1:0] gsel_cfg;
  logic [NUM_SLOTS-1:0]        mask;
  logic [NUM_SLOTS-1:0]        ack_pulse;
  logic                        trig_we;
  logic [NUM_SLOTS-1:0]        pin_tap;
  logic [NUM_SLOTS-1:0]        pin_sync;
  logic [NUM_SLOTS-1:0]        raw_status;
  logic [NUM_SLOTS-1:0]        edge_hit;
  logic                        irq_q, irq_d;

  gpio_irq_regs #(
    .NUM_SLOTS(NUM_SLOTS),
    .GSEL_W   (GSEL_W),
    .DATA_W   (DATA_W),
    .ADDR_W   (ADDR_W)
  ) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .reg_we   (reg_we),
    .reg_addr (reg_addr),
    .reg_wdata(reg_wdata),
    .raw      (raw_status),
    .reg_rdata(reg_rdata),
    .trig_cfg (trig_cfg),
    .gsel_cfg (gsel_cfg),
    .mask     (mask),
    .ack_pulse(ack_pulse),
    .trig_we  (trig_we)
  );

  gpio_irq_lane_mux #(
    .NUM_SLOTS (NUM_SLOTS),
    .LANE_W    (LANE_W),
    .NUM_GROUPS(NUM_GROUPS),
    .GSEL_W    (GSEL_W)
  ) u_mux (
    .pins(gpio_in),
    .gsel(gsel_cfg),
    .tap (pin_tap)
  );

  gpio_irq_sync #(.W(NUM_SLOTS)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    (pin_tap),
    .q    (pin_sync)
  );

  for (genvar k = 0; k < NUM_SLOTS; k++) begin : g_slot
    gpio_irq_slot u_slot (
      .clk     (clk),
      .rst_n   (rst_n),
      .mode    (trig_cfg[k*TRIG_W +: TRIG_W]),
      .pin_s   (pin_sync[k]),
      .ack     (ack_pulse[k]),
      .raw     (raw_status[k]),
      .edge_hit(edge_hit[k])
    );
  end

  assign irq_d = |(raw_status & mask);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= irq_d;
  end

  assign irq = irq_q;

endmodule

// File: rtl/gpio_irq_ctrl_chk.sv
module gpio_irq_ctrl_chk #(
  parameter int unsigned NUM_SLOTS = 8
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic [NUM_SLOTS*3-1:0] trig_cfg,
  input logic [NUM_SLOTS-1:0]   mask,
  input logic [NUM_SLOTS-1:0]   raw,
  input logic [NUM_SLOTS-1:0]   pin_s,
  input logic [NUM_SLOTS-1:0]   ack,
  input logic [NUM_SLOTS-1:0]   edge_hit,
  input logic                   cfg_we,
  input logic                   irq
);

  for (genvar k = 0; k < NUM_SLOTS; k++) begin : g_chk
    logic [2:0] m;
    logic       em;
    assign m  = trig_cfg[k*3 +: 3];
    assign em = (m == 3'd5) || (m == 3'd6) || (m == 3'd7);

    a_r4_off_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      ((m == 3'd0) || (m == 3'd4)) |-> !raw[k]);

    a_r5_level_high: assert property (@(posedge clk) disable iff (!rst_n)
      (m == 3'd1) |-> (raw[k] == pin_s[k]));

    a_r5_level_low: assert property (@(posedge clk) disable iff (!rst_n)
      (m == 3'd2) |-> (raw[k] == !pin_s[k]));

    a_r6_set_forced: assert property (@(posedge clk) disable iff (!rst_n)
      (m == 3'd3) |-> raw[k]);

    a_r7_sticky_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (em && raw[k] && !ack[k] && !cfg_we) |=> raw[k]);

    a_r8_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (em && ack[k] && !edge_hit[k] && !cfg_we) |=> !raw[k]);

    a_r9_edge_wins: assert property (@(posedge clk) disable iff (!rst_n)
      (em && edge_hit[k] && !cfg_we) |=> raw[k]);
  end

  a_r11_irq_rise: assert property (@(posedge clk) disable iff (!rst_n)
    (|(raw & mask)) |=> irq);

  a_r11_irq_fall: assert property (@(posedge clk) disable iff (!rst_n)
    !(|(raw & mask)) |=> !irq);

endmodule

bind gpio_irq_ctrl gpio_irq_ctrl_chk #(.NUM_SLOTS(NUM_SLOTS)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .trig_cfg(trig_cfg),
  .mask    (mask),
  .raw     (raw_status),
  .pin_s   (pin_sync),
  .ack     (ack_pulse),
  .edge_hit(edge_hit),
  .cfg_we  (trig_we),
  .irq     (irq)
);

// File: tb/gpio_irq_ctrl_bench.sv
module gpio_irq_ctrl_bench;

  localparam int unsigned PIN_W = 128;
  localparam logic [2:0] A_TRIG = 3'd0, A_GSEL = 3'd1, A_MASK = 3'd2,
                         A_ACK = 3'd3, A_RAW = 3'd4, A_MSKD = 3'd5;

  logic             clk;
  logic             rst_n;
  logic [PIN_W-1:0] gpio_in;
  logic             reg_we;
  logic [2:0]       reg_addr;
  logic [31:0]      reg_wdata;
  logic [31:0]      reg_rdata;
  logic             irq;

  int n_tests = 0;
  int n_fail  = 0;

  gpio_irq_ctrl u_gpio_irq_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .gpio_in  (gpio_in),
    .reg_we   (reg_we),
    .reg_addr (reg_addr),
    .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata),
    .irq      (irq)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  typedef struct packed {
    logic [3:0] grp;
    logic [2:0] slot;
    logic [2:0] mode;
    logic       v0;
    logic       v1;
    logic       exp;
  } vec_t;

  localparam vec_t VEC [0:11] = '{
    '{4'd0,  3'd0, 3'd1, 1'b0, 1'b1, 1'b1},
    '{4'd5,  3'd3, 3'd2, 1'b0, 1'b1, 1'b0},
    '{4'd9,  3'd2, 3'd2, 1'b1, 1'b0, 1'b1},
    '{4'd15, 3'd7, 3'd5, 1'b0, 1'b1, 1'b1},
    '{4'd15, 3'd7, 3'd5, 1'b1, 1'b0, 1'b0},
    '{4'd3,  3'd4, 3'd6, 1'b1, 1'b0, 1'b1},
    '{4'd3,  3'd4, 3'd6, 1'b0, 1'b1, 1'b0},
    '{4'd12, 3'd1, 3'd7, 1'b0, 1'b1, 1'b1},
    '{4'd12, 3'd1, 3'd7, 1'b1, 1'b0, 1'b1},
    '{4'd6,  3'd5, 3'd3, 1'b0, 1'b0, 1'b1},
    '{4'd6,  3'd5, 3'd4, 1'b0, 1'b1, 1'b0},
    '{4'd10, 3'd6, 3'd0, 1'b0, 1'b1, 1'b0}
  };

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0; reg_wdata = '0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    reg_addr = a;
    #0.5;
    d = reg_rdata;
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic check_reg(input string req, input logic [2:0] a, input logic [31:0] exp);
    logic [31:0] v;
    rd(a, v);
    check(req, v, exp);
  endtask

  initial begin
    #750000;
    n_fail++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; gpio_in = '0; reg_we = 1'b0; reg_addr = '0; reg_wdata = '0;
    tick(4);
    rst_n = 1'b1;
    tick(1);

    // R2: reset state
    for (int a = 0; a < 6; a++) check_reg("R2 reset read", 3'(a), 32'h0);
    check("R2 irq low", {31'b0, irq}, 32'h0);

    // R1: register readback
    wr(A_TRIG, 32'hFFAB_CDEF);
    check_reg("R1 trig readback", A_TRIG, 32'h00AB_CDEF);
    wr(A_GSEL, 32'h89AB_CDEF);
    check_reg("R1 gsel readback", A_GSEL, 32'h89AB_CDEF);
    wr(A_MASK, 32'h1234_56A5);
    check_reg("R1 mask readback", A_MASK, 32'h0000_00A5);
    check_reg("R1 ack reads zero", A_ACK, 32'h0);
    check_reg("R1 unused reads zero", 3'd7, 32'h0);
    wr(A_MASK, 32'h0); wr(A_TRIG, 32'h0); wr(A_GSEL, 32'h0);
    tick(4);

    // Vector walk: R3 R4 R5 R6 R7
    for (int i = 0; i < 12; i++) begin
      automatic vec_t v = VEC[i];
      automatic int idx = int'(v.grp) * 8 + int'(v.slot);
      wr(A_TRIG, 32'h0);
      gpio_in = '0;
      gpio_in[idx] = v.v0;
      tick(4);
      wr(A_GSEL, 32'(v.grp) << (4 * int'(v.slot)));
      tick(4);
      wr(A_TRIG, 32'(v.mode) << (3 * int'(v.slot)));
      wr(A_ACK, 32'hFF);
      gpio_in[idx] = v.v1;
      tick(5);
      check($sformatf("R4 R5 R6 R7 vector %0d mode %0d", i, v.mode), 0, 0);
      n_tests--;
      check_reg($sformatf("R7 vector %0d raw", i), A_RAW, 32'(v.exp) << v.slot);
    end
    wr(A_TRIG, 32'h0); wr(A_GSEL, 32'h0); gpio_in = '0; tick(4);

    // R3: neighbour bit and wrong group are not watched
    wr(A_GSEL, 32'd7 << 8);
    wr(A_TRIG, 32'd1 << 6);
    gpio_in[7*8+3] = 1'b1; tick(4);
    check_reg("R3 neighbour bit ignored", A_RAW, 32'h0);
    gpio_in[6*8+2] = 1'b1; tick(4);
    check_reg("R3 other group ignored", A_RAW, 32'h0);
    gpio_in[7*8+2] = 1'b1; tick(4);
    check_reg("R3 selected bit seen", A_RAW, 32'h4);
    wr(A_TRIG, 32'h0); wr(A_GSEL, 32'h0); gpio_in = '0; tick(4);

    // R11 / R10: latency and irq
    wr(A_TRIG, 32'd1); wr(A_MASK, 32'd1); tick(4);
    gpio_in[0] = 1'b1;
    tick(1);
    check_reg("R11 raw after one edge", A_RAW, 32'h0);
    tick(1);
    check_reg("R11 raw after two edges", A_RAW, 32'h1);
    check("R11 irq not yet", {31'b0, irq}, 32'h0);
    check_reg("R10 masked status", A_MSKD, 32'h1);
    tick(1);
    check("R11 irq asserted", {31'b0, irq}, 32'h1);
    wr(A_ACK, 32'h1);
    check_reg("R5 level ignores ack", A_RAW, 32'h1);
    wr(A_MASK, 32'h0);
    check_reg("R10 masked off", A_MSKD, 32'h0);
    tick(1);
    check("R11 irq drops", {31'b0, irq}, 32'h0);
    gpio_in[0] = 1'b0; tick(3);
    check_reg("R5 level follows low", A_RAW, 32'h0);

    // R7 / R8: sticky edge and acknowledge
    wr(A_TRIG, 32'd5); tick(2);
    gpio_in[0] = 1'b1; tick(3);
    check_reg("R7 rise latched", A_RAW, 32'h1);
    gpio_in[0] = 1'b0; tick(4);
    check_reg("R7 sticky after pin low", A_RAW, 32'h1);
    wr(A_ACK, 32'hFE);
    check_reg("R8 zero bit no effect", A_RAW, 32'h1);
    wr(A_ACK, 32'h01);
    check_reg("R8 one bit clears", A_RAW, 32'h0);

    // R9: acknowledge and edge in the same cycle
    gpio_in[0] = 1'b1;
    tick(2);
    wr(A_ACK, 32'h01);
    check_reg("R9 edge wins over ack", A_RAW, 32'h1);
    wr(A_ACK, 32'h01);
    check_reg("R9 later ack clears", A_RAW, 32'h0);
    gpio_in[0] = 1'b0; tick(4);

    // R10 with partial mask, R6 forced set
    wr(A_TRIG, 32'h1B);
    wr(A_MASK, 32'h2);
    check_reg("R6 set mode raw", A_RAW, 32'h3);
    check_reg("R10 partial mask", A_MSKD, 32'h2);
    tick(1);
    check("R11 irq from slot1", {31'b0, irq}, 32'h1);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule